// File: doc/BRIEF.md
# UART Modem Control Unit

This block sits next to a UART transmitter and plays the terminal side of a modem link. It drives two active-low outputs: a terminal-ready line and a request-to-send line. It also watches four modem inputs: ring, data-set-ready, carrier-detect and clear-to-send. A small register port lets the host do four things: pick the operating mode, turn the terminal-ready line on and off with one-shot strobes, mask interrupts, and read a status word of sticky change flags.

The unit also regulates the transmitter. When clear-to-send goes high, the character on the wire is allowed to finish, and only then is the transmitter held off. When clear-to-send falls again, transmission resumes. The shift register, the baud generator and the receiver lie outside the block. They appear here only as a busy flag, a data-pending flag and an enable output.

Top module: `modem_ctrl`

## Requirements
- R1: Modem behaviour runs only while the mode register (address 0, bits [2:0]) holds 3. In any other mode, `dtr_n_o` and `rts_n_o` sit high, `tx_en_o` is high, input changes set no flag, and flags already set are cleared one cycle after the mode leaves 3.
- R2: A control write (address 1) with bit 0 set enables terminal-ready, and one with bit 1 set disables it. When both bits are set, disable wins. Zero bits have no effect. `dtr_n_o` is low while terminal-ready is enabled in modem mode and high otherwise.
- R3: Each input has its own flag in `stat_o`: bit 0 ring, bit 1 data-set-ready, bit 2 carrier-detect, bit 3 clear-to-send. A rise or a fall on an input that is first sampled at clock edge N sets its flag after edge N+2, and no earlier.
- R4: When `stat_rd_i` is high at a clock edge, all flags clear at that edge. A flag whose input change lands on that same edge stays set.
- R5: The mask register (address 2, bits [3:0], same bit order as `stat_o`) gates the flags: `irq_o` is high exactly when some flag and its mask bit are both set. A mask write takes effect after its clock edge.
- R6: When synchronized clear-to-send is high, `tx_en_o` stays high while `tx_busy_i` is high. It drops in the same cycle that `tx_busy_i` is low, and stays low while clear-to-send remains high.
- R7: After clear-to-send falls and is synchronized (edge N+1 for an input first sampled at edge N), `tx_en_o` is high again, so a new character may start in the next cycle.
- R8: In modem mode, `rts_n_o` goes low one edge after `tx_pending_i` or `tx_busy_i` is high. It returns high one edge after both are low.
- R9: After reset, `stat_o` is 0, `irq_o` is 0, `dtr_n_o` and `rts_n_o` are 1, `tx_en_o` is 1, and the mode register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mode, 1 control, 2 mask |
| reg_wdata_i | input | 8 | Register write data |
| stat_rd_i | input | 1 | Status read strobe; clears the flags |
| stat_o | output | 4 | Sticky change flags |
| irq_o | output | 1 | Masked OR of the flags |
| ri_i | input | 1 | Ring input (asynchronous) |
| dsr_i | input | 1 | Data-set-ready input (asynchronous) |
| dcd_i | input | 1 | Carrier-detect input (asynchronous) |
| cts_i | input | 1 | Clear-to-send input (asynchronous) |
| dtr_n_o | output | 1 | Terminal-ready output, active low |
| rts_n_o | output | 1 | Request-to-send output, active low |
| tx_busy_i | input | 1 | Transmitter is shifting a character |
| tx_pending_i | input | 1 | Transmitter holds unsent data |
| tx_en_o | output | 1 | Transmitter enable |

## Verification
Each result has a fixed latency. A register write shows on `dtr_n_o`, `irq_o` and the mask after its own edge. An input change shows on `stat_o` two edges after it is first sampled, and on `tx_en_o` one edge after that sample. `rts_n_o` follows the transmitter flags by one edge. The bench drives inputs on falling edges and counts rising edges from that point. It checks the cycle just before each result is due as well as the cycle the result appears, and times the read strobe to land on the very edge that sets a flag. Flag patterns and masks are swept exhaustively, and the expected interrupt is computed arithmetically.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int NUM_LINES  = 4;
  localparam int IDX_RI     = 0;
  localparam int IDX_DSR    = 1;
  localparam int IDX_DCD    = 2;
  localparam int IDX_CTS    = 3;
  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;
  localparam int MODE_MODEM = 3;
  localparam int CTRL_ON_BIT  = 0;
  localparam int CTRL_OFF_BIT = 1;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];
  assign chg_o = stg_q[STAGES-1] ^ prev_q;

  // R3: a reported change is always one cycle old in prev_q
  p_chg_tracks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_o != '0) |=> (prev_q == $past(lvl_o)));
endmodule

// File: rtl/modem_flags.sv
module modem_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] chg_i,
  input  logic         rd_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= '0;
    else if (!en_i)  flag_q <= '0;
    else             flag_q <= (flag_q & ~{N{rd_i}}) | chg_i;
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & mask_i);

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && chg_i != '0) |=> ((flags_o & $past(chg_i)) == $past(chg_i)));
  p_read_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && chg_i == '0) |=> (flags_o == '0));
  p_irq_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o & mask_i) == '0) |-> !irq_o);
endmodule

// File: rtl/modem_flow.sv
module modem_flow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic cts_i,
  input  logic busy_i,
  input  logic pending_i,
  output logic tx_en_o,
  output logic rts_n_o
);
  logic halt_q, halt_d, rts_n_q;

  // halt once no character is in flight; hold until clear-to-send drops
  assign halt_d  = on_i & cts_i & (halt_q | ~busy_i);
  assign tx_en_o = ~halt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q  <= 1'b0;
      rts_n_q <= 1'b1;
    end else begin
      halt_q  <= halt_d;
      rts_n_q <= ~(on_i & (pending_i | busy_i));
    end
  end

  assign rts_n_o = rts_n_q;

  p_no_cut_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !halt_q) |-> tx_en_o);
  p_halt_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_q) |-> !$past(busy_i));
  p_resume_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cts_i |-> tx_en_o);
  p_rts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_i && (pending_i || busy_i)) |=> !rts_n_o);
endmodule

// File: rtl/modem_ctrl.sv
module modem_ctrl
  import modem_pkg::*;
#(
  parameter int MODE_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              stat_rd_i,
  output logic [3:0]        stat_o,
  output logic              irq_o,
  input  logic              ri_i,
  input  logic              dsr_i,
  input  logic              dcd_i,
  input  logic              cts_i,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  input  logic              tx_busy_i,
  input  logic              tx_pending_i,
  output logic              tx_en_o
);
  logic [MODE_W-1:0]    mode_q;
  logic                 dtr_en_q;
  logic [NUM_LINES-1:0] mask_q, lines, lvl, chg;
  logic                 modem_on;

  assign modem_on = (mode_q == MODE_W'(MODE_MODEM));

  always_comb begin
    lines          = '0;
    lines[IDX_RI]  = ri_i;
    lines[IDX_DSR] = dsr_i;
    lines[IDX_DCD] = dcd_i;
    lines[IDX_CTS] = cts_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      dtr_en_q <= 1'b0;
      mask_q   <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        ADDR_MODE: mode_q <= reg_wdata_i[MODE_W-1:0];
        ADDR_CTRL: begin
          if (reg_wdata_i[CTRL_OFF_BIT])     dtr_en_q <= 1'b0;
          else if (reg_wdata_i[CTRL_ON_BIT]) dtr_en_q <= 1'b1;
        end
        ADDR_MASK: mask_q <= reg_wdata_i[NUM_LINES-1:0];
        default: ;
      endcase
    end
  end

  assign dtr_n_o = ~(dtr_en_q & modem_on);

  modem_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(lines), .lvl_o(lvl), .chg_o(chg)
  );

  modem_flags #(.N(NUM_LINES)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(modem_on), .chg_i(chg),
    .rd_i(stat_rd_i), .mask_i(mask_q), .flags_o(stat_o), .irq_o(irq_o)
  );

  modem_flow u_flow (
    .clk_i(clk_i), .rst_ni(rst_ni), .on_i(modem_on), .cts_i(lvl[IDX_CTS]),
    .busy_i(tx_busy_i), .pending_i(tx_pending_i),
    .tx_en_o(tx_en_o), .rts_n_o(rts_n_o)
  );

  p_mode_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!modem_on && $past(!modem_on)) |-> (dtr_n_o && rts_n_o && tx_en_o && stat_o == '0));
  p_dtr_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_CTRL && reg_wdata_i[CTRL_OFF_BIT]) |=> dtr_n_o);
endmodule

// File: tb/sim_modem_ctrl.sv
`timescale 1ns/1ps
module sim_modem_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, rd = 1'b0, busy = 1'b0, pend = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] lines = '0;
  logic [3:0] stat;
  logic irq, dtr_n, rts_n, tx_en;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .stat_rd_i(rd), .stat_o(stat), .irq_o(irq),
    .ri_i(lines[0]), .dsr_i(lines[1]), .dcd_i(lines[2]), .cts_i(lines[3]),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .tx_busy_i(busy),
    .tx_pending_i(pend), .tx_en_o(tx_en)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_stat();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R9 reset state
    chk("R9 stat", stat, 0); chk("R9 irq", irq, 0);
    chk("R9 dtr_n", dtr_n, 1); chk("R9 rts_n", rts_n, 1); chk("R9 tx_en", tx_en, 1);

    // R1 / R2 terminal-ready control
    wr(1, 8'h01); chk("R1 dtr off-mode", dtr_n, 1);
    wr(0, 8'h03); chk("R2 dtr enabled", dtr_n, 0);
    wr(1, 8'h00); chk("R2 zero write", dtr_n, 0);
    wr(1, 8'h02); chk("R2 disable", dtr_n, 1);
    wr(1, 8'h00); chk("R2 zero write", dtr_n, 1);
    wr(1, 8'h01); chk("R2 enable", dtr_n, 0);
    wr(1, 8'h03); chk("R2 both bits", dtr_n, 1);
    wr(1, 8'h01); chk("R2 re-enable", dtr_n, 0);

    // R3 per-line flags, rising then falling, with exact latency
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 4; i++) begin
        lines[i] = ~lines[i];
        cyc(2); chk("R3 not yet", stat, 0);
        cyc(1); chk("R3 flag", stat, 8'(1 << i));
        rd_stat(); chk("R4 cleared", stat, 0);
      end
    end

    // R5 exhaustive flag pattern x mask sweep
    for (int p = 1; p < 16; p++) begin
      lines = lines ^ 4'(p);
      cyc(3); chk("R3 pattern", stat, 8'(p));
      for (int m = 0; m < 16; m++) begin
        wr(2, 8'(m));
        chk("R5 irq", irq, ((p & m) != 0) ? 8'd1 : 8'd0);
      end
      rd_stat(); chk("R4 pattern cleared", stat, 0);
      chk("R5 irq after clear", irq, 0);
    end
    wr(2, 8'h00);

    // R4 change on the same edge as a read survives
    lines[0] = 1'b1; cyc(3); chk("R4 setup", stat, 1);
    lines[1] = 1'b1; cyc(2);
    rd_stat(); chk("R4 collision", stat, 8'h02);
    rd_stat(); chk("R4 cleared", stat, 0);
    lines[1:0] = 2'b00; cyc(3); rd_stat();

    // R6 deferred halt, R7 resume
    busy = 1'b1; lines[3] = 1'b1;
    cyc(3); chk("R6 busy holds", tx_en, 1);
    cyc(3); chk("R6 busy holds", tx_en, 1);
    busy = 1'b0; #0.5; chk("R6 halt on idle", tx_en, 0);
    cyc(1); chk("R6 halted", tx_en, 0);
    cyc(2); chk("R6 stays halted", tx_en, 0);
    lines[3] = 1'b0;
    cyc(1); chk("R7 not yet", tx_en, 0);
    cyc(1); chk("R7 resumed", tx_en, 1);
    busy = 1'b1; cyc(1); chk("R7 new char", tx_en, 1);
    busy = 1'b0; cyc(1);
    lines[3] = 1'b1;
    cyc(1); chk("R6 idle pre-sync", tx_en, 1);
    cyc(1); chk("R6 idle halt", tx_en, 0);
    lines[3] = 1'b0; cyc(2); chk("R7 resumed", tx_en, 1);
    cyc(1); rd_stat();

    // R8 request-to-send
    pend = 1'b1; chk("R8 pre-edge", rts_n, 1);
    cyc(1); chk("R8 pending", rts_n, 0);
    pend = 1'b0; busy = 1'b1;
    cyc(1); chk("R8 busy", rts_n, 0);
    busy = 1'b0; chk("R8 pre-release", rts_n, 0);
    cyc(1); chk("R8 released", rts_n, 1);

    // R1 leaving modem mode
    lines[0] = 1'b1; cyc(3); chk("R1 setup", stat, 1);
    wr(0, 8'h00); cyc(1); chk("R1 flags cleared", stat, 0);
    chk("R1 dtr idle", dtr_n, 1);
    pend = 1'b1; cyc(2); chk("R1 rts idle", rts_n, 1); pend = 1'b0;
    lines[3] = 1'b1; cyc(3); chk("R1 tx_en idle", tx_en, 1);
    lines[0] = 1'b0; cyc(3); chk("R1 no flags", stat, 0);
    wr(0, 8'h03); chk("R1 back on stat", stat, 0);
    chk("R1 back on dtr", dtr_n, 0); chk("R1 back on cts halt", tx_en, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule